// File: doc/BRIEF.md
# Output Safety Shutdown Controller

This block sits between a multi-channel PWM generator and the channel output drivers. It forces every channel off in two cases. The first is an over-temperature condition, when thermal shutdown is enabled. The second is the loss of the grayscale PWM clock, when the clock timeout is enabled. Two digital comparator inputs report the junction temperature: one trips at the upper threshold and one releases at the lower threshold. The block keeps a thermal flag with hysteresis between those two inputs, and the configuration register can read that flag without clearing it. The flag is kept whether or not shutdown is enabled.

A timer in the system clock domain watches the PWM clock through a synchroniser. If no rising edge arrives for a programmable number of system cycles, the block turns all outputs off. It keeps them off until two things have both happened, in either order: the PWM clock has toggled again, and the serial interface has reported a fresh data load. At that point the block raises a single-cycle pulse that tells the PWM generator to clear its counters and comparators. The watchdog and the recovery logic keep running during a thermal shutdown, so serial traffic and clock supervision are not interrupted by heat.

Top module: `out_guard`

## Requirements
- R1: While `rst` is high, `chan_o` is all zeros and `therm_flag_o` and `cnt_clear_o` are 0.
- R2: A high level on `hot_trip_i` that lasts at least 4 system cycles sets `therm_flag_o` to 1. This happens whatever the value of `tsd_en_i`.
- R3: Once set, `therm_flag_o` stays 1 while `cool_rel_i` is low, even after `hot_trip_i` has returned low. It clears only when `cool_rel_i` is high and `hot_trip_i` is low.
- R4: While `therm_flag_o` is 1 and `tsd_en_i` is 1, every bit of `chan_o` is 0. With `tsd_en_i` at 0, the flag does not gate the outputs.
- R5: With no shutdown and no clock loss active, `chan_o` equals `chan_en_i` one system cycle later.
- R6: With `wd_dis_i` at 0, if `pwclk_i` shows no rising edge for TIMEOUT_CYC consecutive system cycles (measured after the synchroniser), all bits of `chan_o` go to 0.
- R7: With `wd_dis_i` at 1, no length of PWM-clock idle time turns the outputs off, and a clock-loss state that is already pending is dropped.
- R8: After a clock loss, the outputs stay off until both a rising edge of `pwclk_i` and a one-cycle pulse on `serial_load_i` have been seen, in either order. Neither one alone restores them.
- R9: `cnt_clear_o` is a single-cycle pulse. It rises only in the cycle after recovery from a clock loss completes.
- R10: Clock-loss recovery, including its `cnt_clear_o` pulse, completes during a thermal shutdown. The outputs then stay off until the thermal condition releases.
- R11: If `hot_trip_i` and `cool_rel_i` are both high, the trip wins and `therm_flag_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwclk_i | input | 1 | Grayscale PWM clock, asynchronous to `clk` |
| serial_load_i | input | 1 | One-cycle pulse: new serial data has been shifted in |
| hot_trip_i | input | 1 | Upper-threshold temperature comparator, asynchronous |
| cool_rel_i | input | 1 | Lower-threshold temperature comparator (below release point), asynchronous |
| tsd_en_i | input | 1 | 1 enables thermal shutdown of the outputs |
| wd_dis_i | input | 1 | 1 disables the PWM-clock timeout (0 is the enabled default) |
| chan_en_i | input | CH | Per-channel on requests from the PWM generator |
| chan_o | output | CH | Gated, registered channel outputs |
| therm_flag_o | output | 1 | Thermal flag with hysteresis, not cleared by reading |
| cnt_clear_o | output | 1 | Pulse that clears the PWM counters on restart after a timeout |

## Verification
Several behaviours are checked on every cycle. Outputs are dark one cycle after an enabled thermal flag or a clock-loss state. Outputs track their requests when no guard is active. The flag changes only in the direction its synchronised comparators allow. The timeout cannot be entered while it is disabled. The clear pulse is one cycle wide and follows a loss state. Some behaviours can only be shown by the bench's scenarios. These are the length of the idle window, that a data pulse or a clock edge alone does not restore the outputs, the pulse count across repeated losses, and recovery completing during a shutdown.

// File: rtl/og_pkg.sv
package og_pkg;
  // Clock supervision states
  typedef enum logic [0:0] {
    WD_RUN  = 1'b0,
    WD_LOST = 1'b1
  } wd_state_e;

  // Default number of synchroniser stages for asynchronous inputs
  localparam int unsigned SYNC_DEPTH_DEF = 2;
endpackage

// File: rtl/og_sync.sv
module og_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= '0;
        else     stage_q[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[i] <= '0;
        else     stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/og_thermal.sv
module og_thermal (
  input  logic clk,
  input  logic rst,
  input  logic hot_s,
  input  logic cool_s,
  output logic flag_o
);
  logic flag_q;

  // Set at upper threshold, released only at lower threshold; trip wins.
  always_ff @(posedge clk) begin
    if (rst)         flag_q <= 1'b0;
    else if (hot_s)  flag_q <= 1'b1;
    else if (cool_s) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/og_clk_watch.sv
module og_clk_watch
  import og_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pw_edge_i,
  input  logic load_i,
  input  logic wd_dis_i,
  output logic lost_o,
  output logic clear_o
);
  localparam int unsigned CW  = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC - 1);

  wd_state_e     st_q;
  logic [CW-1:0] idle_q;
  logic          seen_edge_q;
  logic          seen_load_q;
  logic          clear_q;
  logic          got_edge;
  logic          got_load;

  assign got_edge = seen_edge_q | pw_edge_i;
  assign got_load = seen_load_q | load_i;

  always_ff @(posedge clk) begin
    clear_q <= 1'b0;
    if (rst) begin
      st_q        <= WD_RUN;
      idle_q      <= '0;
      seen_edge_q <= 1'b0;
      seen_load_q <= 1'b0;
    end else if (wd_dis_i) begin
      st_q        <= WD_RUN;
      idle_q      <= '0;
      seen_edge_q <= 1'b0;
      seen_load_q <= 1'b0;
    end else begin
      case (st_q)
        WD_RUN: begin
          if (pw_edge_i) begin
            idle_q <= '0;
          end else if (idle_q == LIM) begin
            st_q        <= WD_LOST;
            idle_q      <= '0;
            seen_edge_q <= 1'b0;
            seen_load_q <= 1'b0;
          end else begin
            idle_q <= idle_q + 1'b1;
          end
        end
        WD_LOST: begin
          if (got_edge && got_load) begin
            st_q        <= WD_RUN;
            clear_q     <= 1'b1;
            seen_edge_q <= 1'b0;
            seen_load_q <= 1'b0;
          end else begin
            seen_edge_q <= got_edge;
            seen_load_q <= got_load;
          end
        end
        default: st_q <= WD_RUN;
      endcase
    end
  end

  assign lost_o  = (st_q == WD_LOST);
  assign clear_o = clear_q;
endmodule

// File: rtl/out_guard.sv
module out_guard
  import og_pkg::*;
#(
  parameter int unsigned CH          = 16,
  parameter int unsigned TIMEOUT_CYC = 50_000_000,
  parameter int unsigned SYNC_DEPTH  = SYNC_DEPTH_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwclk_i,
  input  logic          serial_load_i,
  input  logic          hot_trip_i,
  input  logic          cool_rel_i,
  input  logic          tsd_en_i,
  input  logic          wd_dis_i,
  input  logic [CH-1:0] chan_en_i,
  output logic [CH-1:0] chan_o,
  output logic          therm_flag_o,
  output logic          cnt_clear_o
);
  localparam int unsigned NASYNC = 3;

  logic [NASYNC-1:0] async_s;
  logic              pw_s;
  logic              pw_d_q;
  logic              pw_edge;
  logic              hot_s;
  logic              cool_s;
  logic              flag_w;
  logic              lost_w;
  logic              clear_w;
  logic              kill;
  logic [CH-1:0]     chan_q;

  og_sync #(.W(NASYNC), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({pwclk_i, cool_rel_i, hot_trip_i}),
    .q   (async_s)
  );

  assign hot_s  = async_s[0];
  assign cool_s = async_s[1];
  assign pw_s   = async_s[2];

  always_ff @(posedge clk) begin
    if (rst) pw_d_q <= 1'b0;
    else     pw_d_q <= pw_s;
  end

  assign pw_edge = pw_s & ~pw_d_q;

  og_thermal u_thermal (
    .clk    (clk),
    .rst    (rst),
    .hot_s  (hot_s),
    .cool_s (cool_s),
    .flag_o (flag_w)
  );

  og_clk_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
    .clk       (clk),
    .rst       (rst),
    .pw_edge_i (pw_edge),
    .load_i    (serial_load_i),
    .wd_dis_i  (wd_dis_i),
    .lost_o    (lost_w),
    .clear_o   (clear_w)
  );

  assign kill = lost_w | (flag_w & tsd_en_i);

  always_ff @(posedge clk) begin
    if (rst)       chan_q <= '0;
    else if (kill) chan_q <= '0;
    else           chan_q <= chan_en_i;
  end

  assign chan_o       = chan_q;
  assign therm_flag_o = flag_w;
  assign cnt_clear_o  = clear_w;
endmodule

// File: rtl/out_guard_chk.sv
module out_guard_chk #(
  parameter int unsigned CH = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          tsd_en_i,
  input logic          wd_dis_i,
  input logic [CH-1:0] chan_en_i,
  input logic [CH-1:0] chan_o,
  input logic          therm_flag_o,
  input logic          cnt_clear_o,
  input logic          lost,
  input logic          hot_s,
  input logic          cool_s
);
  p_flag_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(therm_flag_o) |-> $past(hot_s));

  p_flag_fall_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(therm_flag_o) |-> $past(cool_s && !hot_s));

  p_hot_dark_r4: assert property (@(posedge clk) disable iff (rst)
    (therm_flag_o && tsd_en_i) |=> (chan_o == '0));

  p_follow_r5: assert property (@(posedge clk) disable iff (rst)
    (!lost && !(therm_flag_o && tsd_en_i)) |=> (chan_o == $past(chan_en_i)));

  p_lost_dark_r6: assert property (@(posedge clk) disable iff (rst)
    lost |=> (chan_o == '0));

  p_dis_no_loss_r7: assert property (@(posedge clk) disable iff (rst)
    wd_dis_i |=> !lost);

  p_clear_single_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_clear_o |=> !cnt_clear_o);

  p_clear_after_loss_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_clear_o |-> ($past(lost) && !lost));
endmodule

bind out_guard out_guard_chk #(.CH(CH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .tsd_en_i     (tsd_en_i),
  .wd_dis_i     (wd_dis_i),
  .chan_en_i    (chan_en_i),
  .chan_o       (chan_o),
  .therm_flag_o (therm_flag_o),
  .cnt_clear_o  (cnt_clear_o),
  .lost         (lost_w),
  .hot_s        (hot_s),
  .cool_s       (cool_s)
);

// File: tb/out_guard_tb_top.sv
module out_guard_tb_top;
  localparam int CLK_P = 10;
  localparam int CH    = 16;
  localparam int TMO   = 64;
  localparam int NVEC  = 8;

  // {hot, cool, tsd_en, chan_en[15:0], exp_flag, exp_chan[15:0]}
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 16'hA5A5, 1'b0, 16'hA5A5},  // R5 plain pass
    {1'b1, 1'b0, 1'b0, 16'h00FF, 1'b1, 16'h00FF},  // R2 flag without enable, R4 no gating
    {1'b1, 1'b0, 1'b1, 16'h00FF, 1'b1, 16'h0000},  // R4 gated
    {1'b0, 1'b0, 1'b1, 16'h1234, 1'b1, 16'h0000},  // R3 hold in band
    {1'b0, 1'b1, 1'b1, 16'h1234, 1'b0, 16'h1234},  // R3 release
    {1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1, 16'h0000},  // R11 trip wins
    {1'b0, 1'b0, 1'b0, 16'hF00F, 1'b1, 16'hF00F},  // R3 hold, R4 disabled
    {1'b0, 1'b1, 1'b1, 16'h8001, 1'b0, 16'h8001}   // R3 release again
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwclk = 1'b0;
  logic          load = 1'b0;
  logic          hot = 1'b0;
  logic          cool = 1'b1;
  logic          tsd_en = 1'b1;
  logic          wd_dis = 1'b0;
  logic [CH-1:0] chan_en = '1;
  logic [CH-1:0] chan_o;
  logic          flag;
  logic          clr;

  logic pw_run = 1'b0;
  bit   done   = 1'b0;
  int   n_chk  = 0;
  int   n_fail = 0;
  int   n_clr  = 0;

  always #(CLK_P/2) clk = ~clk;

  out_guard #(.CH(CH), .TIMEOUT_CYC(TMO)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .pwclk_i       (pwclk),
    .serial_load_i (load),
    .hot_trip_i    (hot),
    .cool_rel_i    (cool),
    .tsd_en_i      (tsd_en),
    .wd_dis_i      (wd_dis),
    .chan_en_i     (chan_en),
    .chan_o        (chan_o),
    .therm_flag_o  (flag),
    .cnt_clear_o   (clr)
  );

  // PWM clock source: toggles every 3 system cycles while running
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      if (pw_run) pwclk = ~pwclk;
    end
  end

  // Clear-pulse counter, sampled once per cycle
  initial begin
    forever begin
      @(negedge clk);
      if (clr) n_clr++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_load();
    load = 1'b1;
    tick(1);
    load = 1'b0;
  endtask

  initial begin
    // R1 reset state
    tick(4);
    chk("R1 chan_o in reset", 32'(chan_o), 32'h0);
    chk("R1 flag in reset", 32'(flag), 32'h0);
    chk("R1 clear in reset", 32'(clr), 32'h0);
    rst    = 1'b0;
    pw_run = 1'b1;
    tick(2);

    // Vector table: R2 R3 R4 R5 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [35:0] v;
      v       = VEC[i];
      hot     = v[35];
      cool    = v[34];
      tsd_en  = v[33];
      chan_en = v[32:17];
      tick(7);
      chk($sformatf("R2/R3/R11 flag vector %0d", i), 32'(flag), 32'(v[16]));
      chk($sformatf("R4/R5 chan_o vector %0d", i), 32'(chan_o), 32'(v[15:0]));
    end
    chk("R9 no clear pulse without loss", 32'(n_clr), 32'd0);

    // R6 timeout
    hot = 1'b0; cool = 1'b1; tsd_en = 1'b1; chan_en = 16'h3C3C;
    tick(4);
    pw_run = 1'b0;
    tick(40);
    chk("R6 still on before window", 32'(chan_o), 32'h3C3C);
    tick(40);
    chk("R6 dark after idle window", 32'(chan_o), 32'h0);

    // R8 data alone does not restore, then clock edge completes recovery
    pulse_load();
    tick(10);
    chk("R8 data pulse alone", 32'(chan_o), 32'h0);
    pw_run = 1'b1;
    tick(20);
    chk("R8 restored after edge and data", 32'(chan_o), 32'h3C3C);
    chk("R9 one clear pulse", 32'(n_clr), 32'd1);

    // R8 clock alone does not restore, then data completes it
    pw_run = 1'b0;
    tick(90);
    chk("R6 dark second loss", 32'(chan_o), 32'h0);
    pw_run = 1'b1;
    tick(25);
    chk("R8 clock alone", 32'(chan_o), 32'h0);
    chk("R9 no pulse yet", 32'(n_clr), 32'd1);
    pulse_load();
    tick(3);
    chk("R8 restored after data", 32'(chan_o), 32'h3C3C);
    chk("R9 second clear pulse", 32'(n_clr), 32'd2);

    // R7 timeout disabled
    wd_dis = 1'b1;
    pw_run = 1'b0;
    tick(150);
    chk("R7 no loss while disabled", 32'(chan_o), 32'h3C3C);
    wd_dis = 1'b0;
    tick(90);
    chk("R6 loss after re-enable", 32'(chan_o), 32'h0);

    // R10 recovery during thermal shutdown
    hot = 1'b1; cool = 1'b0;
    tick(6);
    chk("R10 flag set", 32'(flag), 32'h1);
    pw_run = 1'b1;
    pulse_load();
    tick(20);
    chk("R10 clear pulse while hot", 32'(n_clr), 32'd3);
    chk("R10 outputs dark while hot", 32'(chan_o), 32'h0);
    hot = 1'b0; cool = 1'b1;
    tick(7);
    chk("R10 outputs back after cooling", 32'(chan_o), 32'h3C3C);
    chk("R3 flag released", 32'(flag), 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule